// File: doc/BRIEF.md
# Speculative Load Ordering Violation Detector

This block is a load queue for a core that lets loads run ahead of older stores whose addresses are still unknown. Each load takes a queue slot in program order, together with a wrap-around sequence number. When the load executes it records its full address and whether its data came from an older store. If it did, the slot also records that store's sequence number. Loads leave the queue in order from the head when they retire.

When a store commits, its address and sequence number are compared with every executed load in the queue. A load that is younger than the store, has the same full address, and did not get its data from that store or from a store between the two, read stale data. The block then asks for a replay from the oldest such load. In the same clock edge it drops that load and every younger slot, so the front end can refetch from there and reallocate the freed slots.

Top module: `spec_load_queue`

## Requirements
- R1: After synchronous reset the queue is empty. The count is 0, full is 0, the next allocation tag is 0 and no replay is requested.
- R2: An allocation takes the slot at the tail, whose index is shown on `alloc_tag`, and raises the count by one. At DEPTH entries `lq_full` is 1, and an allocation while full is ignored.
- R3: A retire frees the oldest entry and lowers the count by one. A retire while the queue is empty is ignored.
- R4: A committing store whose sequence number is older than an executed load's, and whose full address equals that load's, raises `replay_valid` one cycle later with that load's tag, provided the load did not forward.
- R5: No replay results when the load has not executed, when the load is older than the store, or when any address bit differs, including a bit above the page offset.
- R6: A load that forwarded from a store with the committing store's sequence number, or a younger one, is not a violation. A load that forwarded from a store older than the committing one is a violation.
- R7: When several loads violate together, `replay_tag` is the oldest of them in queue order.
- R8: A replay frees the violating load and all younger entries. The count becomes the number of entries older than it, and the next allocation reuses its tag.
- R9: In a cycle where a store commit finds a violation, any allocation or retire requested in that cycle is ignored.
- R10: Sequence numbers are compared modulo 2^AGE_W, so ordering holds across the wrap of the counter while fewer than 2^(AGE_W-1) operations are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot for a new load |
| alloc_age | input | AGE_W | Sequence number of the allocated load |
| alloc_tag | output | log2(DEPTH) | Slot index the next allocation will take |
| lq_full | output | 1 | Queue holds DEPTH entries |
| lq_count | output | log2(DEPTH)+1 | Number of occupied entries |
| exec_valid | input | 1 | A load has executed |
| exec_tag | input | log2(DEPTH) | Slot of the executed load |
| exec_addr | input | ADDR_W | Full physical address of the load |
| exec_fwd | input | 1 | Load data came from an older store |
| exec_fwd_age | input | AGE_W | Sequence number of the store that supplied the data |
| retire_valid | input | 1 | Retire the oldest load |
| st_valid | input | 1 | A store commits this cycle |
| st_addr | input | ADDR_W | Full physical address of the committing store |
| st_age | input | AGE_W | Sequence number of the committing store |
| replay_valid | output | 1 | One-cycle replay request |
| replay_tag | output | log2(DEPTH) | Slot of the oldest mis-speculated load |

## Verification
The bench builds the queue with DEPTH 4, AGE_W 4 and ADDR_W 8. A 4-bit sequence number lets one loop of a few thousand cycles wrap the age counter dozens of times. The loop sweeps every combination of store older or younger than the load, executed or not, forwarding source, and matching, low-bit or high-bit address difference, with the ring pointers at every head position. Four slots make it practical to place the first matching load at every position behind every head index, with and without a retire in the commit cycle.

// File: rtl/lq_pkg.sv
package lq_pkg;

    localparam int LQ_DEF_DEPTH  = 8;
    localparam int LQ_DEF_ADDR_W = 40;
    localparam int LQ_DEF_AGE_W  = 7;

    // Lifecycle of one load slot.
    typedef enum logic [1:0] {
        LS_FREE  = 2'd0,
        LS_ALLOC = 2'd1,
        LS_EXEC  = 2'd2
    } lq_state_e;

    // Wrap-aware ordering: given d = a - b truncated to w bits,
    // a lies before b when the top bit of d is set.
    function automatic logic seq_before(input logic [31:0] d, input int unsigned w);
        return d[w-1];
    endfunction

endpackage

// File: rtl/lq_slot.sv
module lq_slot
    import lq_pkg::*;
#(
    parameter int ADDR_W = LQ_DEF_ADDR_W,
    parameter int AGE_W  = LQ_DEF_AGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_we,
    input  logic [AGE_W-1:0]  alloc_age,
    input  logic              exec_we,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              exec_fwd,
    input  logic [AGE_W-1:0]  exec_fwd_age,
    input  logic              free_we,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [AGE_W-1:0]  st_age,
    output logic              busy,
    output logic              hit
);

    typedef struct packed {
        lq_state_e          st;
        logic [AGE_W-1:0]   age;
        logic [ADDR_W-1:0]  addr;
        logic               fwd;
        logic [AGE_W-1:0]   fwd_age;
    } slot_t;

    slot_t ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (free_we) begin
            ent_q.st <= LS_FREE;
        end else if (alloc_we) begin
            ent_q.st      <= LS_ALLOC;
            ent_q.age     <= alloc_age;
            ent_q.fwd     <= 1'b0;
            ent_q.addr    <= '0;
            ent_q.fwd_age <= '0;
        end else if (exec_we && ent_q.st != LS_FREE) begin
            ent_q.st      <= LS_EXEC;
            ent_q.addr    <= exec_addr;
            ent_q.fwd     <= exec_fwd;
            ent_q.fwd_age <= exec_fwd_age;
        end
    end

    logic [AGE_W-1:0] d_store_load;
    logic [AGE_W-1:0] d_src_store;
    logic             store_is_older;
    logic             src_is_older;
    logic             data_ok;

    assign d_store_load   = st_age - ent_q.age;
    assign d_src_store    = ent_q.fwd_age - st_age;
    assign store_is_older = seq_before(32'(d_store_load), AGE_W);
    assign src_is_older   = seq_before(32'(d_src_store), AGE_W);
    // Forwarded data from this store or a later one is already correct.
    assign data_ok        = ent_q.fwd && !src_is_older;

    assign busy = (ent_q.st != LS_FREE);
    assign hit  = st_valid && (ent_q.st == LS_EXEC) && store_is_older &&
                  (ent_q.addr == st_addr) && !data_ok;

endmodule

// File: rtl/lq_oldest_pick.sv
module lq_oldest_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hit,
    input  logic [IDX_W-1:0] head_idx,
    output logic             found,
    output logic [IDX_W-1:0] off
);

    // Scan from the youngest ring position down to the head; the last
    // assignment wins, so the smallest distance from the head is kept.
    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (hit[IDX_W'(head_idx + IDX_W'(k))]) begin
                found = 1'b1;
                off   = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue
    import lq_pkg::*;
#(
    parameter int DEPTH  = LQ_DEF_DEPTH,
    parameter int ADDR_W = LQ_DEF_ADDR_W,
    parameter int AGE_W  = LQ_DEF_AGE_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [AGE_W-1:0]  alloc_age,
    output logic [IDX_W-1:0]  alloc_tag,
    output logic              lq_full,
    output logic [PTR_W-1:0]  lq_count,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_tag,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              exec_fwd,
    input  logic [AGE_W-1:0]  exec_fwd_age,
    input  logic              retire_valid,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [AGE_W-1:0]  st_age,
    output logic              replay_valid,
    output logic [IDX_W-1:0]  replay_tag
);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [DEPTH-1:0] slot_hit, slot_busy, alloc_we, exec_we, free_we;
    logic             viol;
    logic [IDX_W-1:0] pick_off;
    logic             alloc_ok, retire_ok;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign lq_count = tail_q - head_q;
    assign lq_full  = (lq_count == PTR_W'(DEPTH));
    assign alloc_tag = tail_idx;

    // A detected violation owns the cycle: no allocate or retire.
    assign alloc_ok  = alloc_valid && !lq_full && !viol;
    assign retire_ok = retire_valid && (lq_count != '0) && !viol;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [IDX_W-1:0] rel;
        logic             in_q;
        assign rel  = IDX_W'(g) - head_idx;
        assign in_q = (PTR_W'(rel) < lq_count);

        assign alloc_we[g] = alloc_ok && (tail_idx == IDX_W'(g));
        assign exec_we[g]  = exec_valid && !viol && (exec_tag == IDX_W'(g));
        assign free_we[g]  = (retire_ok && head_idx == IDX_W'(g)) ||
                             (viol && in_q && rel >= pick_off);

        lq_slot #(
            .ADDR_W (ADDR_W),
            .AGE_W  (AGE_W)
        ) u_slot (
            .clk          (clk),
            .rst          (rst),
            .alloc_we     (alloc_we[g]),
            .alloc_age    (alloc_age),
            .exec_we      (exec_we[g]),
            .exec_addr    (exec_addr),
            .exec_fwd     (exec_fwd),
            .exec_fwd_age (exec_fwd_age),
            .free_we      (free_we[g]),
            .st_valid     (st_valid),
            .st_addr      (st_addr),
            .st_age       (st_age),
            .busy         (slot_busy[g]),
            .hit          (slot_hit[g])
        );
    end

    lq_oldest_pick #(
        .DEPTH (DEPTH)
    ) u_pick (
        .hit      (slot_hit),
        .head_idx (head_idx),
        .found    (viol),
        .off      (pick_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q       <= '0;
            tail_q       <= '0;
            replay_valid <= 1'b0;
            replay_tag   <= '0;
        end else begin
            replay_valid <= viol;
            if (viol) begin
                replay_tag <= head_idx + pick_off;
                tail_q     <= head_q + PTR_W'(pick_off);
            end else if (alloc_ok) begin
                tail_q <= tail_q + 1'b1;
            end
            if (retire_ok) begin
                head_q <= head_q + 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        lq_count <= PTR_W'(DEPTH));

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (lq_full && alloc_valid && !retire_valid && !st_valid)
        |=> (lq_count == $past(lq_count)));

    a_r3_retire_empty: assert property (@(posedge clk) disable iff (rst)
        (lq_count == '0 && retire_valid && !alloc_valid)
        |=> (lq_count == '0));

    a_r4_replay_follows_commit: assert property (@(posedge clk) disable iff (rst)
        replay_valid |-> $past(st_valid));

    a_r8_tail_rewound: assert property (@(posedge clk) disable iff (rst)
        replay_valid |-> (alloc_tag == replay_tag));

    a_r8_squashed_free: assert property (@(posedge clk) disable iff (rst)
        replay_valid |-> !slot_busy[replay_tag]);

endmodule

// File: tb/tb_spec_load_queue.sv
module tb_spec_load_queue;

    localparam int DEPTH  = 4;
    localparam int ADDR_W = 8;
    localparam int AGE_W  = 4;
    localparam int IDX_W  = 2;
    localparam int PTR_W  = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              alloc_valid;
    logic [AGE_W-1:0]  alloc_age;
    logic [IDX_W-1:0]  alloc_tag;
    logic              lq_full;
    logic [PTR_W-1:0]  lq_count;
    logic              exec_valid;
    logic [IDX_W-1:0]  exec_tag;
    logic [ADDR_W-1:0] exec_addr;
    logic              exec_fwd;
    logic [AGE_W-1:0]  exec_fwd_age;
    logic              retire_valid;
    logic              st_valid;
    logic [ADDR_W-1:0] st_addr;
    logic [AGE_W-1:0]  st_age;
    logic              replay_valid;
    logic [IDX_W-1:0]  replay_tag;

    always #10 clk = ~clk;   // 50 MHz

    spec_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_age(alloc_age), .alloc_tag(alloc_tag),
        .lq_full(lq_full), .lq_count(lq_count),
        .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_addr(exec_addr),
        .exec_fwd(exec_fwd), .exec_fwd_age(exec_fwd_age),
        .retire_valid(retire_valid),
        .st_valid(st_valid), .st_addr(st_addr), .st_age(st_age),
        .replay_valid(replay_valid), .replay_tag(replay_tag)
    );

    int n_chk = 0;
    int n_bad = 0;
    int agc   = 0;   // running load sequence number
    int e_head = 0;
    int e_tail = 0;
    bit done  = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_alloc(input int age);
        alloc_valid = 1'b1; alloc_age = AGE_W'(age);
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic do_exec(input int tag, input int addr, input bit fwd, input int fage);
        exec_valid = 1'b1; exec_tag = IDX_W'(tag); exec_addr = ADDR_W'(addr);
        exec_fwd = fwd; exec_fwd_age = AGE_W'(fage);
        tick();
        exec_valid = 1'b0;
    endtask

    task automatic do_retire();
        retire_valid = 1'b1;
        tick();
        retire_valid = 1'b0;
    endtask

    task automatic do_store(input int addr, input int age, input bit with_retire);
        st_valid = 1'b1; st_addr = ADDR_W'(addr); st_age = AGE_W'(age);
        retire_valid = with_retire;
        tick();
        st_valid = 1'b0; retire_valid = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        alloc_valid = 0; alloc_age = '0; exec_valid = 0; exec_tag = '0;
        exec_addr = '0; exec_fwd = 0; exec_fwd_age = '0; retire_valid = 0;
        st_valid = 0; st_addr = '0; st_age = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // R1: reset state
        chk("R1 count", int'(lq_count), 0);
        chk("R1 full", int'(lq_full), 0);
        chk("R1 tag", int'(alloc_tag), 0);
        chk("R1 replay", int'(replay_valid), 0);

        // R2: fill to DEPTH, then an ignored allocation
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 tag", int'(alloc_tag), i);
            do_alloc(agc % 16); agc++; e_tail++;
            chk("R2 count", int'(lq_count), i + 1);
        end
        chk("R2 full", int'(lq_full), 1);
        do_alloc(agc % 16);
        chk("R2 full alloc ignored", int'(lq_count), DEPTH);
        chk("R2 tag held", int'(alloc_tag), 0);

        // R3: drain in order, then retire on empty
        for (int i = 0; i < DEPTH; i++) begin
            do_retire(); e_head++;
            chk("R3 count", int'(lq_count), DEPTH - 1 - i);
        end
        do_retire();
        chk("R3 empty retire ignored", int'(lq_count), 0);

        // R4 R5 R6 R10: sweep of single-load cases, ages wrap repeatedly
        for (int rep = 0; rep < 16; rep++) begin
            for (int s_young = 0; s_young < 2; s_young++) begin
                for (int amode = 0; amode < 3; amode++) begin
                    for (int ex = 0; ex < 2; ex++) begin
                        for (int fw = 0; fw < 2; fw++) begin
                            for (int fsel = 0; fsel < 2; fsel++) begin
                                int l_age, s_age, f_age, tag, la, sa;
                                bit exp;
                                string req;
                                la    = 8'h5C;
                                sa    = (amode == 0) ? la : (amode == 1) ? (la ^ 8'h80) : (la ^ 8'h01);
                                l_age = agc % 16;
                                s_age = s_young ? (l_age + 1) % 16 : (l_age + 15) % 16;
                                f_age = fsel ? s_age : (s_age + 15) % 16;
                                tag   = e_tail % DEPTH;
                                chk("R2 sweep tag", int'(alloc_tag), tag);
                                do_alloc(l_age); agc++; e_tail++;
                                if (ex) do_exec(tag, la, fw, f_age);
                                exp = ex && !s_young && amode == 0 && !(fw && fsel);
                                if (!ex || s_young || amode != 0) req = "R5 R10";
                                else if (fw) req = "R6 R10";
                                else req = "R4 R10";
                                do_store(sa, s_age, 1'b0);
                                chk(req, int'(replay_valid), int'(exp));
                                if (exp) begin
                                    chk("R4 tag", int'(replay_tag), tag);
                                    e_tail--;
                                    chk("R8 count", int'(lq_count), 0);
                                end else begin
                                    do_retire(); e_head++;
                                    chk("R3 count", int'(lq_count), 0);
                                end
                            end
                        end
                    end
                end
            end
        end

        // R7 R8 R9: first matching load at every position, every head slot
        for (int h = 0; h < DEPTH; h++) begin
            for (int k = 0; k < DEPTH; k++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    int base, hd;
                    base = agc % 16;
                    hd   = e_head % DEPTH;
                    for (int j = 0; j < DEPTH; j++) begin
                        do_alloc((base + 1 + j) % 16); agc++; e_tail++;
                    end
                    agc++;
                    for (int j = 0; j < DEPTH; j++)
                        do_exec((hd + j) % DEPTH, (j < k) ? 8'h33 : 8'hA7, 1'b0, 0);
                    do_store(8'hA7, base, wr[0]);
                    chk("R7 replay", int'(replay_valid), 1);
                    chk("R7 oldest tag", int'(replay_tag), (hd + k) % DEPTH);
                    chk("R9 R8 count", int'(lq_count), k);
                    chk("R8 next tag", int'(alloc_tag), (hd + k) % DEPTH);
                    e_tail = e_head + k;
                    for (int j = 0; j < k; j++) begin
                        do_retire(); e_head++;
                    end
                    chk("R3 drained", int'(lq_count), 0);
                end
            end
            do_alloc(agc % 16); agc++; e_tail++;
            do_retire(); e_head++;
        end

        done = 1;
        report();
        $finish;
    end

endmodule